// File: doc/BRIEF.md
# Two-Level Nested Interrupt Arbiter

This block decides which of fourteen interrupt sources a processor core should service next. Every source carries its own enable bit and its own level bit (high or low), and a single global enable masks the whole set. Among the pending, enabled sources the arbiter offers one as a vector number. High-level requests beat low-level ones. Within a level, the lower source index wins.

The arbiter tracks which levels are currently being serviced. When the core accepts the offered request with an acknowledge strobe, the granted level is marked in service. A return strobe retires the innermost active level. While a low-level handler runs, only a high-level request can be offered. While a high-level handler runs, nothing is offered.

Two of the fourteen sources come from active-low external pins instead of internal request lines. Each pin passes through a two-flop synchronizer. It can be used in level mode, where a low pin requests directly. It can also be used in edge mode, where a falling edge sets a latched flag that holds until that source is acknowledged.

The nesting state is held in a four-state machine:
- `ST_IDLE`: nothing is in service.
- `ST_LO`: a low-level handler is in service.
- `ST_HI`: a high-level handler is in service, with no low-level handler underneath.
- `ST_HI_NEST`: a high-level handler is in service on top of a low-level handler.

The transitions are:
- `ST_IDLE` goes to `ST_HI` on an accepted high grant, or to `ST_LO` on an accepted low grant.
- `ST_LO` goes to `ST_HI_NEST` on an accepted high grant, or to `ST_IDLE` on return.
- `ST_HI` goes to `ST_IDLE` on return.
- `ST_HI_NEST` goes to `ST_LO` on return.

Top module: `irq_nest_arbiter`

## Requirements
- R1: While `glob_en` is 0, `irq_valid` is 0 whatever requests are pending.
- R2: A source whose `src_en` bit is 0 is never offered, even when it requests.
- R3: With nothing in service and pending requests at both levels, the offered source is a high-level one (`src_hi` bit 1 means high), and `irq_level` is 1.
- R4: Among pending sources of the same level, the lowest index is offered. The fixed order is: 0 X0 (external pin 0), 1 ADC, 2 T0, 3 CT0, 4 CM0, 5 X1 (external pin 1), 6 CT1, 7 CM1, 8 T1, 9 CT2, 10 CM2, 11 S0, 12 CT3, 13 T2. `irq_vec` carries the index in binary.
- R5: While only the low level is in service (`in_svc` = 01), low-level requests are not offered, but a high-level request is.
- R6: While the high level is in service (`in_svc[1]` = 1), `irq_valid` is 0.
- R7: An `ack` in a cycle where `irq_valid` is 1 and `reti` is 0 marks the offered level in service from the next cycle on: bit 0 of `in_svc` for low, bit 1 for high. An `ack` without `irq_valid`, or together with `reti`, changes nothing.
- R8: A `reti` clears the highest set bit of `in_svc`, so 11 becomes 01, 01 becomes 00, and 10 becomes 00.
- R9: In level mode (`ext_edge` bit 0), a low level on `ext_n[k]` requests source 0 (k=0) or source 5 (k=1). The request appears after two clock edges and disappears two edges after the pin returns high.
- R10: In edge mode (`ext_edge` bit 1), a falling edge on `ext_n[k]` latches a request. The request persists after the pin returns high and is cleared by an accepted acknowledge of that source. A pin held low does not raise it again.
- R11: The `src_req` bits at positions 0 and 5 have no effect; those sources are driven only by the external pins.
- R12: After reset, `in_svc` is 00 and no edge request is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | 14 | Internal request lines, one per source index; bits 0 and 5 are unused |
| ext_n | input | 2 | Active-low external request pins for sources 0 and 5 |
| ext_edge | input | 2 | Per-pin mode: 1 selects edge, 0 selects level |
| src_en | input | 14 | Per-source enable |
| src_hi | input | 14 | Per-source level: 1 is high, 0 is low |
| glob_en | input | 1 | Global enable |
| ack | input | 1 | Core accepts the offered request |
| reti | input | 1 | Core returns from the innermost handler |
| irq_valid | output | 1 | A request is offered |
| irq_vec | output | 4 | Index of the offered source |
| irq_level | output | 1 | Level of the offered source |
| in_svc | output | 2 | Levels in service: bit 1 high, bit 0 low |

## Verification
The checker watches several rules on every cycle:
- the masking by the global and per-source enables;
- the silence of the arbiter while the high level is in service;
- that only high-level requests are offered above a running low-level handler;
- the state change after every accepted acknowledge and every return.

Other behaviours depend on the history of stimulus, so only the bench's directed scenarios can show them. These are:
- the exact fixed order within a level;
- the two-edge latency of the pin synchronizer;
- the persistence of an edge latch after the pin releases, and its clearing by the acknowledge;
- the inertness of the request bits shadowed by the external pins.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LO      = 2'd1,
        ST_HI      = 2'd2,
        ST_HI_NEST = 2'd3
    } nest_state_t;
endpackage

// File: rtl/irq_ext_sync.sv
module irq_ext_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic active
);
    logic s1, s2, s3, flag;
    logic fall;

    assign fall = s3 & ~s2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1   <= 1'b1;
            s2   <= 1'b1;
            s3   <= 1'b1;
            flag <= 1'b0;
        end else begin
            s1 <= pin_n;
            s2 <= s1;
            s3 <= s2;
            if (!edge_mode)
                flag <= 1'b0;
            else if (fall)
                flag <= 1'b1;
            else if (clr)
                flag <= 1'b0;
        end
    end

    assign active = edge_mode ? flag : ~s2;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int W  = 14,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/irq_nest_arbiter.sv
module irq_nest_arbiter
    import irq_pkg::*;
#(
    parameter int NUM_SRC  = 14,
    parameter int EXT0_POS = 0,
    parameter int EXT1_POS = 5,
    localparam int VW      = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [1:0]         ext_n,
    input  logic [1:0]         ext_edge,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_SRC-1:0] src_hi,
    input  logic               glob_en,
    input  logic               ack,
    input  logic               reti,
    output logic               irq_valid,
    output logic [VW-1:0]      irq_vec,
    output logic               irq_level,
    output logic [1:0]         in_svc
);
    nest_state_t state, state_nx;
    logic [1:0]         ext_act;
    logic [1:0]         ext_clr;
    logic [NUM_SRC-1:0] eff_req, pend;
    logic               hi_found, lo_found;
    logic [VW-1:0]      hi_idx, lo_idx;
    logic               take;

    localparam int EXT_POS [2] = '{EXT0_POS, EXT1_POS};

    assign take = ack & ~reti & irq_valid;

    for (genvar k = 0; k < 2; k++) begin : g_ext
        assign ext_clr[k] = take && (irq_vec == VW'(EXT_POS[k]));
        irq_ext_sync u_sync (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_n[k]),
            .edge_mode (ext_edge[k]),
            .clr       (ext_clr[k]),
            .active    (ext_act[k])
        );
    end

    always_comb begin
        eff_req           = src_req;
        eff_req[EXT0_POS] = ext_act[0];
        eff_req[EXT1_POS] = ext_act[1];
        pend              = eff_req & src_en & {NUM_SRC{glob_en}};
    end

    irq_prio_pick #(.W(NUM_SRC), .IW(VW)) u_pick_hi (
        .req   (pend & src_hi),
        .found (hi_found),
        .idx   (hi_idx)
    );

    irq_prio_pick #(.W(NUM_SRC), .IW(VW)) u_pick_lo (
        .req   (pend & ~src_hi),
        .found (lo_found),
        .idx   (lo_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (take) state_nx = irq_level ? ST_HI : ST_LO;
            end
            ST_LO: begin
                if (reti)      state_nx = ST_IDLE;
                else if (take) state_nx = ST_HI_NEST;
            end
            ST_HI: begin
                if (reti) state_nx = ST_IDLE;
            end
            ST_HI_NEST: begin
                if (reti) state_nx = ST_LO;
            end
        endcase
    end

    always_comb begin
        irq_valid = 1'b0;
        irq_vec   = '0;
        irq_level = 1'b0;
        in_svc    = 2'b00;
        unique case (state)
            ST_IDLE: begin
                if (hi_found) begin
                    irq_valid = 1'b1;
                    irq_vec   = hi_idx;
                    irq_level = 1'b1;
                end else if (lo_found) begin
                    irq_valid = 1'b1;
                    irq_vec   = lo_idx;
                end
            end
            ST_LO: begin
                in_svc = 2'b01;
                if (hi_found) begin
                    irq_valid = 1'b1;
                    irq_vec   = hi_idx;
                    irq_level = 1'b1;
                end
            end
            ST_HI:      in_svc = 2'b10;
            ST_HI_NEST: in_svc = 2'b11;
        endcase
    end
endmodule

// File: rtl/irq_nest_arbiter_chk.sv
module irq_nest_arbiter_chk #(
    parameter int NUM_SRC = 14,
    localparam int VW     = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_en,
    input logic               glob_en,
    input logic               ack,
    input logic               reti,
    input logic               irq_valid,
    input logic [VW-1:0]      irq_vec,
    input logic               irq_level,
    input logic [1:0]         in_svc
);
    // R1
    glob_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |-> !irq_valid);

    // R2
    src_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> src_en[irq_vec]);

    // R5
    lo_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_svc == 2'b01 && irq_valid) |-> irq_level);

    // R6
    hi_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_svc[1] |-> !irq_valid);

    // R7
    ack_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !reti && irq_valid && irq_level) |=> in_svc[1]);

    // R7
    ack_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !reti && irq_valid && !irq_level) |=> in_svc == 2'b01);

    // R8
    reti_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && in_svc == 2'b11) |=> in_svc == 2'b01);

    // R8
    reti_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && (in_svc == 2'b01 || in_svc == 2'b10)) |=> in_svc == 2'b00);
endmodule

bind irq_nest_arbiter irq_nest_arbiter_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_en    (src_en),
    .glob_en   (glob_en),
    .ack       (ack),
    .reti      (reti),
    .irq_valid (irq_valid),
    .irq_vec   (irq_vec),
    .irq_level (irq_level),
    .in_svc    (in_svc)
);

// File: tb/irq_nest_arbiter_tb.sv
module irq_nest_arbiter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] src_req = '0;
    logic [1:0]  ext_n = 2'b11;
    logic [1:0]  ext_edge = 2'b00;
    logic [13:0] src_en = '1;
    logic [13:0] src_hi = '0;
    logic        glob_en = 1'b1;
    logic        ack = 1'b0;
    logic        reti = 1'b0;
    logic        irq_valid;
    logic [3:0]  irq_vec;
    logic        irq_level;
    logic [1:0]  in_svc;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_nest_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .ext_n(ext_n),
        .ext_edge(ext_edge), .src_en(src_en), .src_hi(src_hi),
        .glob_en(glob_en), .ack(ack), .reti(reti), .irq_valid(irq_valid),
        .irq_vec(irq_vec), .irq_level(irq_level), .in_svc(in_svc)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_none(input string tag);
        chk(tag, int'(irq_valid), 0);
    endtask

    task automatic chk_grant(input string tag, input int lvl, input int vec);
        chk(tag, int'({irq_valid, irq_level, irq_vec}), (1 << 5) | (lvl << 4) | vec);
    endtask

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        #2;
    endtask

    task automatic pulse_reti();
        @(negedge clk); reti = 1'b1;
        @(negedge clk); reti = 1'b0;
        #2;
    endtask

    task automatic t_reset();
        ext_edge = 2'b11;
        settle();
        chk("R12 in_svc after reset", int'(in_svc), 0);
        chk_none("R12 no latched edge after reset");
        ext_edge = 2'b00;
    endtask

    task automatic t_global();
        src_req = 14'b1 << 2;
        glob_en = 1'b0;
        settle();
        chk_none("R1 global disable masks");
        glob_en = 1'b1;
        settle();
        chk_grant("R1 global enable passes", 0, 2);
        src_req = '0;
    endtask

    task automatic t_enable();
        src_req = (14'b1 << 3) | (14'b1 << 8);
        src_en  = ~(14'b1 << 3);
        settle();
        chk_grant("R2 disabled source skipped", 0, 8);
        src_en  = '1;
        src_req = '0;
    endtask

    task automatic t_order();
        src_req = (14'b1 << 13) | (14'b1 << 9) | (14'b1 << 4);
        settle();
        chk_grant("R4 order 4 over 9,13", 0, 4);
        src_req = (14'b1 << 13) | (14'b1 << 9);
        settle();
        chk_grant("R4 order 9 over 13", 0, 9);
        src_req = (14'b1 << 12) | (14'b1 << 11);
        settle();
        chk_grant("R4 order 11 over 12", 0, 11);
        src_req = '0;
    endtask

    task automatic t_hi_first();
        src_req = (14'b1 << 1) | (14'b1 << 10);
        src_hi  = 14'b1 << 10;
        settle();
        chk_grant("R3 high beats low", 1, 10);
        src_req = '0;
        src_hi  = '0;
    endtask

    task automatic t_nest();
        src_req = 14'b1 << 1;
        settle();
        pulse_ack();
        chk("R7 low ack sets in_svc", int'(in_svc), 1);
        chk_none("R5 low blocked under low");
        src_req = (14'b1 << 1) | (14'b1 << 10);
        src_hi  = 14'b1 << 10;
        settle();
        chk_grant("R5 high offered under low", 1, 10);
        pulse_ack();
        chk("R7 high ack nests", int'(in_svc), 3);
        src_req = (14'b1 << 1) | (14'b1 << 10) | (14'b1 << 6);
        src_hi  = (14'b1 << 10) | (14'b1 << 6);
        settle();
        chk_none("R6 nothing under high");
        src_req = '0;
        src_hi  = '0;
        pulse_reti();
        chk("R8 reti clears high first", int'(in_svc), 1);
        pulse_reti();
        chk("R8 reti clears low", int'(in_svc), 0);
    endtask

    task automatic t_ack_ignored();
        pulse_ack();
        chk("R7 ack without valid ignored", int'(in_svc), 0);
        src_req = 14'b1 << 7;
        @(negedge clk); ack = 1'b1; reti = 1'b1;
        @(negedge clk); ack = 1'b0; reti = 1'b0;
        #2;
        chk("R7 ack with reti ignored", int'(in_svc), 0);
        src_req = '0;
    endtask

    task automatic t_ext_level();
        ext_edge = 2'b00;
        @(negedge clk); ext_n[0] = 1'b0;
        #2 chk_none("R9 no request at zero edges");
        settle();
        chk_none("R9 no request after one edge");
        settle();
        chk_grant("R9 level request after two edges", 0, 0);
        ext_n[0] = 1'b1;
        settle();
        settle();
        chk_none("R9 level request drops with pin");
    endtask

    task automatic t_ext_edge();
        ext_edge = 2'b10;
        @(negedge clk); ext_n[1] = 1'b0;
        @(negedge clk); ext_n[1] = 1'b1;
        repeat (4) @(negedge clk);
        #2 chk_grant("R10 edge latched after release", 0, 5);
        pulse_ack();
        pulse_reti();
        chk_none("R10 edge latch cleared by ack");
        @(negedge clk); ext_n[1] = 1'b0;
        repeat (4) @(negedge clk);
        #2 chk_grant("R10 held-low latches once", 0, 5);
        pulse_ack();
        pulse_reti();
        chk_none("R10 held low does not retrigger");
        ext_n[1] = 1'b1;
        settle();
        settle();
        ext_edge = 2'b00;
    endtask

    task automatic t_shadow_bits();
        src_req = (14'b1 << 0) | (14'b1 << 5);
        settle();
        chk_none("R11 shadowed request bits ignored");
        src_req = '0;
    endtask

    initial begin
        #100000000;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_global();
        t_enable();
        t_order();
        t_hi_first();
        t_nest();
        t_ack_ignored();
        t_ext_level();
        t_ext_edge();
        t_shadow_bits();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule